// File: doc/BRIEF.md
# Fetch Thread Selector for a Multithreaded Core

This block chooses, on every cycle, which hardware thread of a simultaneous multithreaded core may fetch. For each thread it tracks three indicators of outstanding pipeline work: instructions in flight, low-confidence branches not yet resolved, and predicted cache misses not yet completed. It combines them into one work value with programmable weights and grants fetch to the eligible thread with the smallest value.

A thread is eligible when it is not stalled and its in-flight count is below its own cap. Ties in work value go to the first eligible thread found when scanning upward from a rotating pointer, so equal threads take turns. The indicators are updated from single-cycle event pulses sent by the pipeline and the predictors. A pipeline flush of a thread subtracts a reported squash count. The grant is combinational from the registered counters and the current stall, cap and weight inputs.

Top module: `fetch_thread_sel`

## Requirements
- R1: `fetch_gnt` has at most one bit set in every cycle.
- R2: A thread whose `thr_stall` bit is high is never granted.
- R3: A thread whose in-flight count is greater than or equal to its `inflight_cap` slice (bits t*CW upward) is never granted.
- R4: The work value of thread t is `wt_inst`×inflight + `wt_lcb`×branches + `wt_miss`×misses, at full precision. The grant goes to the eligible thread with the smallest work value.
- R5: Among eligible threads that tie on the smallest work value, the first one found is granted. The scan runs from the pointer in ascending index order and wraps from NTHR-1 to 0. After a cycle with a grant to thread i, the pointer becomes (i+1) mod NTHR.
- R6: When no thread is eligible, `fetch_gnt` is all zeros and the pointer keeps its value.
- R7: The in-flight count rises by 1 on `ev_inst_in` and falls by 1 on `ev_inst_out`. Both in one cycle leave it unchanged. It saturates at 0 and at 2^CW-1.
- R8: When `flush` is high for a thread, the `squash_cnt` slice for that thread is also subtracted from its in-flight count in the same cycle. The result floors at 0.
- R9: The branch and miss counters rise on `ev_lcb_in`/`ev_miss_in` and fall on `ev_lcb_out`/`ev_miss_out`. They saturate at 0 and at 2^CW-1.
- R10: After reset all counters are zero and the pointer is 0. With no stall and non-zero caps, the grant is thread 0.
- R11: A counter event sampled at a clock edge is reflected in `fetch_gnt` during the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wt_inst | input | WW | Weight of the in-flight count |
| wt_lcb | input | WW | Weight of the low-confidence branch count |
| wt_miss | input | WW | Weight of the predicted miss count |
| inflight_cap | input | NTHR*CW | Per-thread cap on in-flight instructions |
| thr_stall | input | NTHR | Per-thread stall, blocks the grant |
| ev_inst_in | input | NTHR | Instruction entered the window |
| ev_inst_out | input | NTHR | Instruction left the window |
| ev_lcb_in | input | NTHR | Low-confidence branch fetched |
| ev_lcb_out | input | NTHR | Low-confidence branch resolved |
| ev_miss_in | input | NTHR | Predicted cache miss issued |
| ev_miss_out | input | NTHR | Predicted cache miss completed |
| flush | input | NTHR | Pipeline flush of the thread |
| squash_cnt | input | NTHR*CW | Instructions squashed by the flush, per thread |
| fetch_gnt | output | NTHR | One-hot fetch grant, zero when nobody is eligible |

## Verification
The hardest situation to reach is a counter pinned at a saturation bound while another thread sits just beside it in work value. Only then does the clamp decide the grant. Random events rarely drive a count to 2^CW-1 or push a flush below zero. A directed phase therefore pumps one thread far past the upper bound and a second to an exact value, then steps both down so that only clamped arithmetic picks the right winner. It also flushes a thread by more than it holds. Long random runs with narrow weights and frequent stalls produce many ties, which exercise the rotating pointer.

// File: rtl/fts_pkg.sv
package fts_pkg;
  // limit an integer to the range [0, hi]
  function automatic int clamp_int(input int v, input int hi);
    if (v < 0) return 0;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/fts_thread_ctr.sv
module fts_thread_ctr #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inst_in,
  input  logic          inst_out,
  input  logic          lcb_in,
  input  logic          lcb_out,
  input  logic          miss_in,
  input  logic          miss_out,
  input  logic          flush,
  input  logic [CW-1:0] squash,
  output logic [CW-1:0] infl,
  output logic [CW-1:0] lcb,
  output logic [CW-1:0] miss
);
  import fts_pkg::*;
  localparam int MAXV = (1 << CW) - 1;

  logic [CW-1:0] infl_q, infl_d, lcb_q, lcb_d, miss_q, miss_d;
  logic          infl_en, lcb_en, miss_en;

  always_comb begin
    int t_i, t_l, t_m;
    t_i = int'(infl_q) + int'(inst_in) - int'(inst_out) - (flush ? int'(squash) : 0);
    t_l = int'(lcb_q) + int'(lcb_in) - int'(lcb_out);
    t_m = int'(miss_q) + int'(miss_in) - int'(miss_out);
    infl_d  = CW'(clamp_int(t_i, MAXV));
    lcb_d   = CW'(clamp_int(t_l, MAXV));
    miss_d  = CW'(clamp_int(t_m, MAXV));
    infl_en = inst_in | inst_out | flush;
    lcb_en  = lcb_in | lcb_out;
    miss_en = miss_in | miss_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      infl_q <= '0;
      lcb_q  <= '0;
      miss_q <= '0;
    end else begin
      if (infl_en) infl_q <= infl_d;
      if (lcb_en)  lcb_q  <= lcb_d;
      if (miss_en) miss_q <= miss_d;
    end
  end

  assign infl = infl_q;
  assign lcb  = lcb_q;
  assign miss = miss_q;
endmodule

// File: rtl/fts_work_sum.sv
module fts_work_sum #(
  parameter int CW  = 5,
  parameter int WW  = 4,
  parameter int WKW = CW + WW + 2
) (
  input  logic [WW-1:0]  w_i,
  input  logic [WW-1:0]  w_l,
  input  logic [WW-1:0]  w_m,
  input  logic [CW-1:0]  c_i,
  input  logic [CW-1:0]  c_l,
  input  logic [CW-1:0]  c_m,
  output logic [WKW-1:0] work
);
  always_comb begin
    work = WKW'(w_i) * WKW'(c_i) + WKW'(w_l) * WKW'(c_l) + WKW'(w_m) * WKW'(c_m);
  end
endmodule

// File: rtl/fts_pick.sv
module fts_pick #(
  parameter int NTHR = 4,
  parameter int WKW  = 11,
  parameter int PW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTHR-1:0]     elig,
  input  logic [NTHR*WKW-1:0] work_flat,
  output logic [NTHR-1:0]     gnt
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic          found;

  always_comb begin
    logic [WKW-1:0] best;
    int             sel;
    found = 1'b0;
    best  = '0;
    sel   = 0;
    for (int k = 0; k < NTHR; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % NTHR;
      if (elig[idx] && (!found || work_flat[idx*WKW +: WKW] < best)) begin
        found = 1'b1;
        best  = work_flat[idx*WKW +: WKW];
        sel   = idx;
      end
    end
    gnt   = found ? (NTHR'(1) << sel) : '0;
    ptr_d = PW'((sel + 1) % NTHR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (found) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NTHR = 4,
  parameter int CW   = 5,
  parameter int WW   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WW-1:0]       wt_inst,
  input  logic [WW-1:0]       wt_lcb,
  input  logic [WW-1:0]       wt_miss,
  input  logic [NTHR*CW-1:0]  inflight_cap,
  input  logic [NTHR-1:0]     thr_stall,
  input  logic [NTHR-1:0]     ev_inst_in,
  input  logic [NTHR-1:0]     ev_inst_out,
  input  logic [NTHR-1:0]     ev_lcb_in,
  input  logic [NTHR-1:0]     ev_lcb_out,
  input  logic [NTHR-1:0]     ev_miss_in,
  input  logic [NTHR-1:0]     ev_miss_out,
  input  logic [NTHR-1:0]     flush,
  input  logic [NTHR*CW-1:0]  squash_cnt,
  output logic [NTHR-1:0]     fetch_gnt
);
  localparam int WKW = CW + WW + 2;

  logic                rst_s1, rst_sn;
  logic [NTHR*CW-1:0]  infl_flat;
  logic [NTHR*WKW-1:0] work_flat;
  logic [NTHR-1:0]     elig;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [CW-1:0] c_i, c_l, c_m;

    fts_thread_ctr #(.CW(CW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_sn),
      .inst_in  (ev_inst_in[t]),
      .inst_out (ev_inst_out[t]),
      .lcb_in   (ev_lcb_in[t]),
      .lcb_out  (ev_lcb_out[t]),
      .miss_in  (ev_miss_in[t]),
      .miss_out (ev_miss_out[t]),
      .flush    (flush[t]),
      .squash   (squash_cnt[t*CW +: CW]),
      .infl     (c_i),
      .lcb      (c_l),
      .miss     (c_m)
    );

    fts_work_sum #(.CW(CW), .WW(WW), .WKW(WKW)) u_sum (
      .w_i  (wt_inst),
      .w_l  (wt_lcb),
      .w_m  (wt_miss),
      .c_i  (c_i),
      .c_l  (c_l),
      .c_m  (c_m),
      .work (work_flat[t*WKW +: WKW])
    );

    assign infl_flat[t*CW +: CW] = c_i;
    assign elig[t] = !thr_stall[t] && (infl_flat[t*CW +: CW] < inflight_cap[t*CW +: CW]);
  end

  fts_pick #(.NTHR(NTHR), .WKW(WKW)) u_pick (
    .clk       (clk),
    .rst_n     (rst_sn),
    .elig      (elig),
    .work_flat (work_flat),
    .gnt       (fetch_gnt)
  );
endmodule

// File: rtl/fts_chk.sv
module fts_chk #(
  parameter int NTHR = 4,
  parameter int CW   = 5,
  parameter int PW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic               clk,
  input logic               rst_sn,
  input logic [NTHR-1:0]    gnt,
  input logic [NTHR-1:0]    stall,
  input logic [NTHR*CW-1:0] cap,
  input logic [NTHR*CW-1:0] infl,
  input logic [NTHR-1:0]    inst_in,
  input logic [NTHR-1:0]    inst_out,
  input logic [NTHR-1:0]    flush,
  input logic [PW-1:0]      ptr
);
  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sn) $onehot0(gnt));

  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_sn) (gnt & stall) == '0);

  // R6
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_sn) (gnt == '0) |=> $stable(ptr));

  for (genvar t = 0; t < NTHR; t++) begin : g_c
    // R3
    cap_block_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      gnt[t] |-> (infl[t*CW +: CW] < cap[t*CW +: CW]));

    // R7
    floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      (infl[t*CW +: CW] == '0 && !inst_in[t] && !flush[t]) |=> (infl[t*CW +: CW] == '0));
  end
endmodule

bind fetch_thread_sel fts_chk #(.NTHR(NTHR), .CW(CW)) u_fts_chk (
  .clk      (clk),
  .rst_sn   (rst_sn),
  .gnt      (fetch_gnt),
  .stall    (thr_stall),
  .cap      (inflight_cap),
  .infl     (infl_flat),
  .inst_in  (ev_inst_in),
  .inst_out (ev_inst_out),
  .flush    (flush),
  .ptr      (u_pick.ptr_q)
);

// File: tb/fetch_thread_sel_bench.sv
module fetch_thread_sel_bench;
  localparam int NTHR = 4;
  localparam int CW   = 5;
  localparam int WW   = 4;
  localparam int TCLK = 10;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WW-1:0] wt_inst, wt_lcb, wt_miss;
  logic [NTHR*CW-1:0] inflight_cap, squash_cnt;
  logic [NTHR-1:0] thr_stall, ev_inst_in, ev_inst_out, ev_lcb_in, ev_lcb_out;
  logic [NTHR-1:0] ev_miss_in, ev_miss_out, flush, fetch_gnt;

  int n_run = 0, n_fail = 0;
  int m_inf[NTHR], m_lcb[NTHR], m_mis[NTHR];
  int m_ptr;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  fetch_thread_sel #(.NTHR(NTHR), .CW(CW), .WW(WW)) u_fetch_thread_sel (.*);

  function automatic int clampv(int v);
    return (v < 0) ? 0 : ((v > MAXV) ? MAXV : v);
  endfunction

  function automatic logic [NTHR-1:0] exp_gnt();
    int best, sel;
    bit found;
    found = 0; best = 0; sel = 0;
    for (int k = 0; k < NTHR; k++) begin
      int i, w;
      i = (m_ptr + k) % NTHR;
      w = int'(wt_inst) * m_inf[i] + int'(wt_lcb) * m_lcb[i] + int'(wt_miss) * m_mis[i];
      if (!thr_stall[i] && m_inf[i] < int'(inflight_cap[i*CW +: CW]) && (!found || w < best)) begin
        found = 1; best = w; sel = i;
      end
    end
    return found ? (NTHR'(1) << sel) : '0;
  endfunction

  task automatic clear_ev();
    ev_inst_in = '0; ev_inst_out = '0; ev_lcb_in = '0; ev_lcb_out = '0;
    ev_miss_in = '0; ev_miss_out = '0; flush = '0; squash_cnt = '0;
  endtask

  task automatic check(string tag);
    logic [NTHR-1:0] e;
    e = exp_gnt();
    n_run++;
    if (fetch_gnt !== e) begin
      n_fail++;
      $display("FAIL %s: fetch_gnt got %b expected %b", tag, fetch_gnt, e);
    end
  endtask

  // inputs are set at the falling edge; check, then clock, then update model
  task automatic step(string tag);
    logic [NTHR-1:0] e;
    #1;
    check(tag);
    e = exp_gnt();
    @(posedge clk);
    for (int t = 0; t < NTHR; t++) begin
      m_inf[t] = clampv(m_inf[t] + int'(ev_inst_in[t]) - int'(ev_inst_out[t])
                 - (flush[t] ? int'(squash_cnt[t*CW +: CW]) : 0));
      m_lcb[t] = clampv(m_lcb[t] + int'(ev_lcb_in[t]) - int'(ev_lcb_out[t]));
      m_mis[t] = clampv(m_mis[t] + int'(ev_miss_in[t]) - int'(ev_miss_out[t]));
    end
    for (int t = 0; t < NTHR; t++) if (e[t]) m_ptr = (t + 1) % NTHR;
    @(negedge clk);
    clear_ev();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    clear_ev();
    wt_inst = 4'd1; wt_lcb = 4'd0; wt_miss = 4'd0;
    thr_stall = '1;
    for (int t = 0; t < NTHR; t++) inflight_cap[t*CW +: CW] = CW'(MAXV);
    for (int t = 0; t < NTHR; t++) begin m_inf[t] = 0; m_lcb[t] = 0; m_mis[t] = 0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state grants thread 0
    thr_stall = '0;
    #1; n_run++;
    if (fetch_gnt !== 4'b0001) begin
      n_fail++; $display("FAIL R10: fetch_gnt got %b expected 0001", fetch_gnt);
    end
    // R5: equal work rotates
    for (int i = 0; i < 6; i++) step("R5 rotation");
    // R6: nobody eligible
    thr_stall = '1;
    step("R6 idle");
    step("R6 idle");
    thr_stall = '0;
    step("R6 pointer kept");
    // R3: cap of zero blocks thread
    inflight_cap[0 +: CW] = '0;
    for (int i = 0; i < 4; i++) step("R3 cap");
    inflight_cap[0 +: CW] = CW'(MAXV);
    // R11 / R4: single event moves the winner next cycle
    ev_inst_in = 4'b0111;
    step("R11 event");
    step("R11 R4 after event");
    // R7: saturation at top and netting
    thr_stall = 4'b1100;
    for (int i = 0; i < 40; i++) begin ev_inst_in = 4'b0011; if (i >= 31) ev_inst_in = 4'b0001; step("R7 fill"); end
    ev_inst_out = 4'b0011; step("R7 drain");
    ev_inst_out = 4'b0001; step("R7 drain");
    ev_inst_in = 4'b0011; ev_inst_out = 4'b0011; step("R7 net zero");
    step("R7 saturated compare");
    // R8: flush, including below zero
    flush = 4'b0011; squash_cnt[0 +: CW] = 5'd10; squash_cnt[CW +: CW] = 5'd31;
    step("R8 flush");
    step("R8 after flush");
    flush = 4'b0001; squash_cnt[0 +: CW] = 5'd31; step("R8 floor");
    step("R8 floor result");
    // R9: branch and miss counters with their own weights
    thr_stall = '0;
    wt_inst = 4'd0; wt_lcb = 4'd3; wt_miss = 4'd2;
    for (int i = 0; i < 35; i++) begin ev_lcb_in = 4'b0001; ev_miss_in = 4'b0010; step("R9 fill"); end
    for (int i = 0; i < 3; i++) begin ev_lcb_out = 4'b0001; ev_miss_out = 4'b0110; step("R9 drain"); end
    step("R9 result");

    // random phase: R1 R2 R3 R4 R5 R6
    for (int n = 0; n < 4000; n++) begin
      if (n % 200 == 0) begin
        wt_inst = WW'($urandom_range(0, 3));
        wt_lcb  = WW'($urandom_range(0, 3));
        wt_miss = WW'($urandom_range(0, 3));
        for (int t = 0; t < NTHR; t++) inflight_cap[t*CW +: CW] = CW'($urandom_range(0, MAXV));
      end
      for (int t = 0; t < NTHR; t++) begin
        thr_stall[t]   = ($urandom_range(0, 3) == 0);
        ev_inst_in[t]  = $urandom_range(0, 1);
        ev_inst_out[t] = $urandom_range(0, 1);
        ev_lcb_in[t]   = ($urandom_range(0, 3) == 0);
        ev_lcb_out[t]  = ($urandom_range(0, 3) == 0);
        ev_miss_in[t]  = ($urandom_range(0, 3) == 0);
        ev_miss_out[t] = ($urandom_range(0, 3) == 0);
        flush[t]       = ($urandom_range(0, 49) == 0);
        squash_cnt[t*CW +: CW] = CW'($urandom_range(0, 12));
      end
      step("R1 R2 R3 R4 R5 R6 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule